// File: doc/BRIEF.md
# SPI Master Interrupt Status and Mask Unit

This unit gathers the interrupt causes of an SPI master whose transmit and receive FIFOs each hold 32 entries. It turns them into one level-sensitive interrupt request. Three causes are sticky events. They arrive as single-cycle pulses: transmit underflow, receive overflow and mode fault. Each one is held in a status bit until software writes a 1 to that bit. The other four causes are recomputed every cycle from the FIFO occupancy counts. Two of those four compare a count against a programmable threshold rather than testing for empty or full.

Software reaches the unit over a simple word-addressed register bus. Writes take effect at the clock edge where the strobe is sampled, and read data appears one cycle after the read strobe. A set-only enable register and a clear-only disable register edit the interrupt mask. The mask itself can be read but not written. The interrupt line is high whenever any status bit is set that the mask also holds.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Reading the status word (address 0) returns receive overflow in bit 0, mode fault in bit 1, transmit-below-threshold in bit 2, transmit full in bit 3, receive-at-threshold in bit 4, receive full in bit 5 and transmit underflow in bit 6; every bit above 6 reads 0.
- R2: Status bits 0, 1 and 6 are set by a one-cycle pulse on their event input and then stay set with no further pulse until software clears them.
- R3: A write to address 0 clears each sticky status bit whose write-data bit is 1 and leaves each bit written 0 unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends set.
- R5: Bit 3 reads 1 exactly when the transmit count equals 32, and bit 5 reads 1 exactly when the receive count equals 32, following the counts with no memory.
- R6: Bit 4 reads 1 exactly when the receive count is greater than or equal to the receive threshold (address 5); a threshold of 0 keeps it set.
- R7: Bit 2 reads 1 exactly when the transmit count is strictly below the transmit threshold (address 4); a threshold of 0 keeps it clear.
- R8: A write to address 1 ORs write-data bits 6:0 into the mask. A write to address 2 clears those bits from the mask. Address 3 reads the mask. Writes to address 3 are ignored, and reads of addresses 1 and 2 return 0.
- R9: The interrupt output is high one cycle after any bit of (mask AND status) is set, and low one cycle after none is.
- R10: After reset both thresholds read 1 and the mask and the sticky bits read 0. Each threshold register stores write-data bits 5:0, so it holds 0 to 63.
- R11: Read data is valid in the cycle after the read strobe. It is 0 in any cycle that follows no read, and 0 for addresses 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| tx_level | input | 6 | Transmit FIFO occupancy, 0 to 32 |
| rx_level | input | 6 | Receive FIFO occupancy, 0 to 32 |
| ev_tx_underflow | input | 1 | One-cycle transmit underflow pulse |
| ev_rx_overflow | input | 1 | One-cycle receive overflow pulse |
| ev_mode_fault | input | 1 | One-cycle mode fault pulse |
| irq | output | 1 | Level interrupt request |

## Verification
Events, status clears, mask edits and threshold writes all take effect at the edge that samples them. The live bits follow the counts in the same cycle. A read of any of this state is therefore due one cycle after the read strobe, and the interrupt line is due one edge after the state that drives it. The bench drives inputs on the falling edge and samples outputs on the next falling edge, which covers exactly one rising edge. Its reference model advances once per rising edge and predicts read data and the interrupt level for that sample. Directed checks that expect the interrupt to follow a clear or an event wait one falling edge for the state change and one more for the output.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

   localparam int IRQ_BITS = 7;

   // word addresses
   localparam int REG_STATUS = 0;
   localparam int REG_SETEN  = 1;
   localparam int REG_CLREN  = 2;
   localparam int REG_MASK   = 3;
   localparam int REG_TXTHR  = 4;
   localparam int REG_RXTHR  = 5;

   // status bit positions
   localparam int BIT_RXOVF  = 0;
   localparam int BIT_MODEF  = 1;
   localparam int BIT_TXLOW  = 2;
   localparam int BIT_TXFULL = 3;
   localparam int BIT_RXLVL  = 4;
   localparam int BIT_RXFULL = 5;
   localparam int BIT_TXUNF  = 6;

   localparam int STICKY_N = 3;

   typedef struct packed {
      logic txunf;
      logic rxfull;
      logic rxlvl;
      logic txfull;
      logic txlow;
      logic modef;
      logic rxovf;
   } irq_vec_t;

endpackage

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= 1'b0;
         else if (set_i[i])
            q <= 1'b1;          // the event has priority over the clear
         else if (clr_i[i])
            q <= 1'b0;
      end
      assign q_o[i] = q;
   end
endmodule

// File: rtl/spi_irq_level.sv
module spi_irq_level #(
   parameter int DEPTH = 32,
   parameter int CNT_W = 6,
   parameter int THR_W = 6
) (
   input  logic [CNT_W-1:0] tx_cnt_i,
   input  logic [CNT_W-1:0] rx_cnt_i,
   input  logic [THR_W-1:0] tx_thr_i,
   input  logic [THR_W-1:0] rx_thr_i,
   output logic             tx_low_o,
   output logic             tx_full_o,
   output logic             rx_lvl_o,
   output logic             rx_full_o
);
   localparam int CMP_W = ((CNT_W > THR_W) ? CNT_W : THR_W) + 1;
   localparam logic [CMP_W-1:0] FULL_V = CMP_W'(DEPTH);

   logic [CMP_W-1:0] tx_c, rx_c, tx_t, rx_t;

   always_comb begin
      tx_c = CMP_W'(tx_cnt_i);
      rx_c = CMP_W'(rx_cnt_i);
      tx_t = CMP_W'(tx_thr_i);
      rx_t = CMP_W'(rx_thr_i);
      tx_full_o = (tx_c >= FULL_V);
      rx_full_o = (rx_c >= FULL_V);
      tx_low_o  = (tx_c <  tx_t);
      rx_lvl_o  = (rx_c >= rx_t);
   end
endmodule

// File: rtl/spi_irq_regbank.sv
module spi_irq_regbank #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32,
   parameter int THR_W  = 6,
   parameter int NB     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [NB-1:0]     status_i,
   output logic [NB-1:0]     mask_o,
   output logic [NB-1:0]     clr_o,
   output logic [THR_W-1:0]  tx_thr_o,
   output logic [THR_W-1:0]  rx_thr_o,
   output logic [DATA_W-1:0] rdata_o
);
   import spi_irq_pkg::*;

   localparam int LOW_W = (NB > THR_W) ? NB : THR_W;
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
   localparam logic [ADDR_W-1:0] A_SETEN  = ADDR_W'(REG_SETEN);
   localparam logic [ADDR_W-1:0] A_CLREN  = ADDR_W'(REG_CLREN);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(REG_MASK);
   localparam logic [ADDR_W-1:0] A_TXTHR  = ADDR_W'(REG_TXTHR);
   localparam logic [ADDR_W-1:0] A_RXTHR  = ADDR_W'(REG_RXTHR);
   localparam logic [THR_W-1:0]  THR_RST  = THR_W'(1);

   logic [NB-1:0]     mask_q;
   logic [THR_W-1:0]  txthr_q, rxthr_q;
   logic [DATA_W-1:0] rd_mux;
   logic [NB-1:0]     wbits;
   logic              unused_wdata_hi;

   assign wbits           = wdata_i[NB-1:0];
   assign unused_wdata_hi = ^wdata_i[DATA_W-1:LOW_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         txthr_q <= THR_RST;
         rxthr_q <= THR_RST;
      end else if (wr_i) begin
         case (addr_i)
            A_SETEN: mask_q  <= mask_q | wbits;
            A_CLREN: mask_q  <= mask_q & ~wbits;
            A_TXTHR: txthr_q <= wdata_i[THR_W-1:0];
            A_RXTHR: rxthr_q <= wdata_i[THR_W-1:0];
            default: ;
         endcase
      end
   end

   assign clr_o = (wr_i && addr_i == A_STATUS) ? wbits : '0;

   always_comb begin
      rd_mux = '0;
      case (addr_i)
         A_STATUS: rd_mux = DATA_W'(status_i);
         A_MASK:   rd_mux = DATA_W'(mask_q);
         A_TXTHR:  rd_mux = DATA_W'(txthr_q);
         A_RXTHR:  rd_mux = DATA_W'(rxthr_q);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_o <= '0;
      else
         rdata_o <= rd_i ? rd_mux : '0;
   end

   assign mask_o   = mask_q;
   assign tx_thr_o = txthr_q;
   assign rx_thr_o = rxthr_q;
endmodule

// File: rtl/spi_irq_drive.sv
module spi_irq_drive #(
   parameter int NB      = 7,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] status_i,
   input  logic [NB-1:0] mask_i,
   output logic          irq_o
);
   logic any_w;
   assign any_w = |(status_i & mask_i);

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_w;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_o = any_w;
   end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl #(
   parameter int FIFO_DEPTH = 32,
   parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
   parameter int THR_W      = 6,
   parameter int ADDR_W     = 3,
   parameter int DATA_W     = 32,
   parameter bit IRQ_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [CNT_W-1:0]  tx_level,
   input  logic [CNT_W-1:0]  rx_level,
   input  logic              ev_tx_underflow,
   input  logic              ev_rx_overflow,
   input  logic              ev_mode_fault,
   output logic              irq
);
   import spi_irq_pkg::*;

   localparam int NB = IRQ_BITS;

   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("FIFO_DEPTH must be at least 2");
   end
   if (CNT_W < $clog2(FIFO_DEPTH + 1)) begin : g_bad_cnt
      $error("CNT_W too narrow for FIFO_DEPTH");
   end
   if (THR_W < CNT_W) begin : g_bad_thr
      $error("THR_W must cover the full count range");
   end
   if (DATA_W <= NB || DATA_W <= THR_W) begin : g_bad_data
      $error("DATA_W too narrow");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must reach six registers");
   end

   irq_vec_t             status_w;
   logic [NB-1:0]        status_bits;
   logic [NB-1:0]        mask_q;
   logic [NB-1:0]        clr_w;
   logic [THR_W-1:0]     tx_thr, rx_thr;
   logic [STICKY_N-1:0]  st_set, st_clr, st_q;
   logic                 tx_low, tx_full, rx_lvl, rx_full;

   assign st_set = {ev_tx_underflow, ev_mode_fault, ev_rx_overflow};
   assign st_clr = {clr_w[BIT_TXUNF], clr_w[BIT_MODEF], clr_w[BIT_RXOVF]};

   spi_irq_sticky #(.N(STICKY_N)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (st_set),
      .clr_i (st_clr),
      .q_o   (st_q)
   );

   spi_irq_level #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .THR_W(THR_W)) u_level (
      .tx_cnt_i  (tx_level),
      .rx_cnt_i  (rx_level),
      .tx_thr_i  (tx_thr),
      .rx_thr_i  (rx_thr),
      .tx_low_o  (tx_low),
      .tx_full_o (tx_full),
      .rx_lvl_o  (rx_lvl),
      .rx_full_o (rx_full)
   );

   always_comb begin
      status_w.rxovf  = st_q[0];
      status_w.modef  = st_q[1];
      status_w.txunf  = st_q[2];
      status_w.txlow  = tx_low;
      status_w.txfull = tx_full;
      status_w.rxlvl  = rx_lvl;
      status_w.rxfull = rx_full;
   end
   assign status_bits = status_w;

   spi_irq_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .THR_W(THR_W), .NB(NB)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (reg_wr),
      .rd_i     (reg_rd),
      .addr_i   (reg_addr),
      .wdata_i  (reg_wdata),
      .status_i (status_bits),
      .mask_o   (mask_q),
      .clr_o    (clr_w),
      .tx_thr_o (tx_thr),
      .rx_thr_o (rx_thr),
      .rdata_o  (reg_rdata)
   );

   spi_irq_drive #(.NB(NB), .IRQ_REG(IRQ_REG)) u_drive (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_bits),
      .mask_i   (mask_q),
      .irq_o    (irq)
   );
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk #(
   parameter int FIFO_DEPTH = 32,
   parameter int CNT_W      = 6,
   parameter int ADDR_W     = 3,
   parameter int DATA_W     = 32,
   parameter bit IRQ_REG    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [CNT_W-1:0]  tx_level,
   input logic [CNT_W-1:0]  rx_level,
   input logic              ev_tx_underflow,
   input logic              ev_rx_overflow,
   input logic              ev_mode_fault,
   input logic              irq,
   input logic [6:0]        mask,
   input logic [6:0]        status
);
   localparam logic [ADDR_W-1:0] A0 = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A1 = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A2 = ADDR_W'(2);
   localparam logic [CNT_W-1:0]  FULLC = CNT_W'(FIFO_DEPTH);

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_rx_overflow && !(reg_wr && reg_addr == A0 && reg_wdata[0])) |=> $stable(status[0])); // R2
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A0 && reg_wdata[1] && !ev_mode_fault) |=> !status[1]); // R3
   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tx_underflow |=> status[6]); // R4
   AST_TX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level == FULLC) |-> status[3]); // R5
   AST_RX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level != FULLC) |-> !status[5]); // R5
   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A1) |=> ((mask & $past(reg_wdata[6:0])) == $past(reg_wdata[6:0]))); // R8
   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A2) |=> ((mask & $past(reg_wdata[6:0])) == 7'd0)); // R8
   AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A0) |=> (reg_rdata[DATA_W-1:7] == '0)); // R1
   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> (reg_rdata == '0)); // R11

   if (IRQ_REG) begin : g_irq_reg
      AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(|(mask & status)))); // R9
   end else begin : g_irq_comb
      always_comb begin
         if (rst_n) begin
            AST_IRQ_LEVEL: assert (irq == |(mask & status)); // R9
         end
      end
   end
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(
   .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
   .DATA_W(DATA_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .tx_level(tx_level), .rx_level(rx_level),
   .ev_tx_underflow(ev_tx_underflow), .ev_rx_overflow(ev_rx_overflow),
   .ev_mode_fault(ev_mode_fault), .irq(irq),
   .mask(mask_q), .status(status_bits)
);

// File: tb/spi_irq_ctrl_test.sv
`timescale 1ns/1ps
module spi_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [5:0]  tx_level = '0, rx_level = '0;
   logic        ev_tx_underflow = 1'b0, ev_rx_overflow = 1'b0, ev_mode_fault = 1'b0;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   spi_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_level(tx_level), .rx_level(rx_level),
      .ev_tx_underflow(ev_tx_underflow), .ev_rx_overflow(ev_rx_overflow),
      .ev_mode_fault(ev_mode_fault), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [6:0]  m_sticky, m_mask;
   int          m_txthr, m_rxthr;
   logic        m_irq;
   logic [31:0] m_rdata;
   string       m_rtag;
   logic [6:0]  m_status;

   function automatic logic [6:0] live_bits(int tx, int rx, int txt, int rxt);
      logic [6:0] v = '0;
      v[2] = (tx < txt);
      v[3] = (tx == 32);
      v[4] = (rx >= rxt);
      v[5] = (rx == 32);
      return v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sticky <= '0; m_mask <= '0; m_txthr <= 1; m_rxthr <= 1;
         m_irq <= 1'b0; m_rdata <= '0; m_rtag <= "R11 idle";
      end else begin
         m_status = m_sticky | live_bits(int'(tx_level), int'(rx_level), m_txthr, m_rxthr);
         m_irq <= |(m_status & m_mask);
         if (reg_rd) begin
            case (int'(reg_addr))
               0: begin m_rdata <= {25'd0, m_status};        m_rtag <= "R1 status read"; end
               1, 2: begin m_rdata <= '0;                    m_rtag <= "R8 enable/disable read"; end
               3: begin m_rdata <= {25'd0, m_mask};          m_rtag <= "R8 mask read"; end
               4: begin m_rdata <= 32'(m_txthr);             m_rtag <= "R10 tx threshold read"; end
               5: begin m_rdata <= 32'(m_rxthr);             m_rtag <= "R10 rx threshold read"; end
               default: begin m_rdata <= '0;                 m_rtag <= "R11 unmapped read"; end
            endcase
         end else begin
            m_rdata <= '0; m_rtag <= "R11 idle";
         end
         begin
            logic [6:0] s;
            s = m_sticky;
            if (reg_wr && reg_addr == 3'd0) s = s & ~(reg_wdata[6:0] & 7'h43);
            if (ev_rx_overflow)  s[0] = 1'b1;
            if (ev_mode_fault)   s[1] = 1'b1;
            if (ev_tx_underflow) s[6] = 1'b1;
            m_sticky <= s;
         end
         if (reg_wr) begin
            case (int'(reg_addr))
               1: m_mask <= m_mask | reg_wdata[6:0];
               2: m_mask <= m_mask & ~reg_wdata[6:0];
               4: m_txthr <= int'(reg_wdata[5:0]);
               5: m_rxthr <= int'(reg_wdata[5:0]);
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R9 irq vs model", {31'd0, irq}, {31'd0, m_irq});
         chk(m_rtag, reg_rdata, m_rdata);
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
      @(negedge clk); reg_rd = 1'b1; reg_addr = 3'(a);
      @(negedge clk); reg_rd = 1'b0;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      ev_rx_overflow = (which == 0); ev_mode_fault = (which == 1); ev_tx_underflow = (which == 6);
      @(negedge clk);
      ev_rx_overflow = 1'b0; ev_mode_fault = 1'b0; ev_tx_underflow = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      chk("R10 irq low after reset", {31'd0, irq}, 32'd0);
      // reset state
      rd_chk(0, 32'h04, "R10 status after reset (only bit2)");
      rd_chk(4, 32'd1, "R10 tx threshold reset");
      rd_chk(5, 32'd1, "R10 rx threshold reset");
      rd_chk(3, 32'd0, "R10 mask reset");
      // sticky latch
      pulse(0);
      rd_chk(0, 32'h05, "R2 overflow latched");
      repeat (5) @(negedge clk);
      rd_chk(0, 32'h05, "R2 overflow held");
      // write-one-to-clear
      wr(0, 32'h02);
      rd_chk(0, 32'h05, "R3 zero bit kept, other bit untouched");
      wr(0, 32'hFFFF_FF01 & 32'h0000_0001);
      rd_chk(0, 32'h04, "R3 overflow cleared");
      // event wins against clear
      pulse(1);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h40; ev_tx_underflow = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; ev_tx_underflow = 1'b0;
      rd_chk(0, 32'h46, "R4 underflow survives same-cycle clear");
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h02; ev_mode_fault = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; ev_mode_fault = 1'b0;
      rd_chk(0, 32'h46, "R4 mode fault survives same-cycle clear");
      // full flags
      tx_level = 6'd32;
      rd_chk(0, 32'h4A, "R5 tx full");
      rx_level = 6'd32;
      rd_chk(0, 32'h7A, "R5 rx full and at threshold");
      tx_level = 6'd31; rx_level = 6'd31;
      rd_chk(0, 32'h52, "R5 not full at 31");
      tx_level = 6'd0; rx_level = 6'd0;
      rd_chk(0, 32'h46, "R5 empty fifos");
      // receive threshold
      wr(5, 32'd5);
      rx_level = 6'd4;
      rd_chk(0, 32'h46, "R6 rx below threshold");
      rx_level = 6'd5;
      rd_chk(0, 32'h56, "R6 rx equal to threshold");
      rx_level = 6'd0;
      wr(5, 32'd0);
      rd_chk(0, 32'h56, "R6 threshold 0 always set");
      // transmit threshold
      wr(4, 32'd10);
      tx_level = 6'd9;
      rd_chk(0, 32'h56, "R7 tx below threshold");
      tx_level = 6'd10;
      rd_chk(0, 32'h52, "R7 tx equal to threshold");
      tx_level = 6'd0;
      wr(4, 32'd0);
      rd_chk(0, 32'h52, "R7 threshold 0 never set");
      wr(4, 32'h1C5);
      rd_chk(4, 32'd5, "R10 tx threshold keeps bits 5:0");
      wr(5, 32'd63);
      rd_chk(5, 32'd63, "R10 rx threshold holds 63");
      wr(4, 32'd1); wr(5, 32'd1);
      rd_chk(0, 32'h46, "R1 status layout restored");
      // mask
      wr(1, 32'h10);
      rd_chk(3, 32'h10, "R8 enable sets mask");
      wr(1, 32'h01);
      rd_chk(3, 32'h11, "R8 enable ORs");
      wr(2, 32'h10);
      rd_chk(3, 32'h01, "R8 disable clears");
      wr(3, 32'h7F);
      rd_chk(3, 32'h01, "R8 mask write ignored");
      rd_chk(1, 32'h0, "R8 enable reads zero");
      rd_chk(2, 32'h0, "R8 disable reads zero");
      // interrupt timing
      chk("R9 irq low with masked causes off", {31'd0, irq}, 32'd0);
      pulse(0);
      chk("R9 irq not yet high", {31'd0, irq}, 32'd0);
      @(negedge clk);
      chk("R9 irq high one cycle after status", {31'd0, irq}, 32'd1);
      wr(0, 32'h01);
      chk("R9 irq still high at clear edge", {31'd0, irq}, 32'd1);
      @(negedge clk);
      chk("R9 irq low after clear", {31'd0, irq}, 32'd0);
      wr(1, 32'h04);
      @(negedge clk);
      chk("R7 tx low raises irq", {31'd0, irq}, 32'd1);
      tx_level = 6'd5;
      @(negedge clk);
      @(negedge clk);
      chk("R7 tx above threshold drops irq", {31'd0, irq}, 32'd0);
      // read path
      rd_chk(7, 32'h0, "R11 unmapped address");
      rd_chk(6, 32'h0, "R11 unmapped address 6");
      @(negedge clk);
      chk("R11 no read gives zero", reg_rdata, 32'h0);
      // mixed traffic against the model
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         reg_wr = ($urandom_range(0, 3) == 0);
         reg_rd = ($urandom_range(0, 1) == 0);
         reg_addr = 3'($urandom_range(0, 7));
         reg_wdata = $urandom;
         if (reg_wr && (reg_addr == 3'd4 || reg_addr == 3'd5) && $urandom_range(0, 1) == 0)
            reg_wdata = 32'($urandom_range(0, 33));
         tx_level = 6'($urandom_range(0, 32));
         rx_level = 6'($urandom_range(0, 32));
         ev_rx_overflow  = ($urandom_range(0, 15) == 0);
         ev_mode_fault   = ($urandom_range(0, 15) == 0);
         ev_tx_underflow = ($urandom_range(0, 15) == 0);
      end
      @(negedge clk);
      reg_wr = 1'b0; reg_rd = 1'b0;
      ev_rx_overflow = 1'b0; ev_mode_fault = 1'b0; ev_tx_underflow = 1'b0;
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule